// File: doc/BRIEF.md
# Word-Wide CRC-32 Peripheral on APB

This block is a memory-mapped checksum engine. Software restarts the running checksum, writes the message one 32-bit word at a time, and then reads the finished checksum. Each data write folds the whole word into a 32-bit remainder in the clock cycle of the write. There is no input queue. The generator polynomial, the start value and the input and output bit-reversal are fixed when the block is built. The final XOR mask is a register that software can read and overwrite.

The register window sits on an APB slave with 8-bit addresses and 32-bit data. It holds four read-only registers: an identity word, a version word, a build-options word and the result. It also holds two write-only command registers and the read/write XOR mask. With the default build, a message of little-endian 32-bit words gives the usual reflected CRC-32 of that byte stream.

Top module: `wordcrc_periph`

## Requirements
- R1: After a synchronous active-low reset, the remainder equals the start value 0xFFFFFFFF and the XOR mask (offset 0x018) reads 0xFFFFFFFF, so the result at offset 0x014 reads 0x00000000.
- R2: A write to offset 0x010 folds the 32-bit word into the remainder in one cycle. A single word 0x00000000 after a restart yields 0x2144DF1C. A run of words yields the reflected CRC-32 (polynomial 0x04C11DB7) of those words taken as little-endian byte streams.
- R3: A write of any value to offset 0x00C returns the remainder to the start value. The written data has no effect.
- R4: Offset 0x014 reads the bit-reversed remainder XORed with the mask register. Offset 0x018 reads back the last value written to it, and changing it changes the result at once.
- R5: Offset 0x008 reads the build options: bits 7:0 = 32 (the order), bit 8 = input reversal on, bit 9 = output reversal on, bit 10 = writable mask present, all other bits 0. The default build reads 0x00000720.
- R6: Offset 0x000 reads 0x00080012: bits 31:24 API version 0, bits 23:16 window length 8, bits 15:0 identity 0x12. Offset 0x004 reads 0x01000000: major 1 in bits 31:24, minor 0 in bits 23:16, patch 0 in bits 15:0.
- R7: Reads of offsets 0x00C and 0x010, of unmapped offsets and of unaligned offsets return 0. Writes to offsets 0x000, 0x004, 0x008, 0x014 and to unmapped offsets change nothing.
- R8: PREADY is high and PSLVERR is low in every cycle.
- R9: A write takes effect only in the access phase (PSEL, PENABLE and PWRITE high). A setup phase that is not followed by an access phase leaves all state unchanged.
- R10: The effect of a write is visible to the next transfer, with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset into the register window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |

## Verification
The folding function gets the all-zero word, which pins the bit order against the known constant 0x2144DF1C. It also gets an all-ones word and alternating 0xA5/0x5A bytes, which expose a wrong polynomial tap or a byte swap. A walking one shows a single misplaced bit in the input reversal, and a long pseudo-random stream checks chained state against a shift-right bench model. Changes to the mask, restarts with non-zero data, writes to read-only offsets and an aborted setup phase sit between these streams, so a stale or wrongly updated remainder shows up on the next result read.

// File: rtl/wordcrc_pkg.sv
// wordcrc_pkg: offsets, identity constants and shared types of the
// word-wide CRC peripheral. Assumes an 8-bit byte-addressed window.
package wordcrc_pkg;

    localparam int unsigned CRC_W = 32;

    // register offsets (byte addresses)
    localparam logic [7:0] OFS_IDENT   = 8'h00;
    localparam logic [7:0] OFS_VERSION = 8'h04;
    localparam logic [7:0] OFS_CONFIG  = 8'h08;
    localparam logic [7:0] OFS_RESTART = 8'h0C;
    localparam logic [7:0] OFS_FEED    = 8'h10;
    localparam logic [7:0] OFS_RESULT  = 8'h14;
    localparam logic [7:0] OFS_FINXOR  = 8'h18;

    // identity and version fields
    localparam logic [7:0]  IDENT_API   = 8'h00;
    localparam logic [7:0]  IDENT_LEN   = 8'h08;
    localparam logic [15:0] IDENT_NUM   = 16'h0012;
    localparam logic [7:0]  VER_MAJOR   = 8'h01;
    localparam logic [7:0]  VER_MINOR   = 8'h00;
    localparam logic [15:0] VER_PATCH   = 16'h0000;

    // read source selected by the address decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_VERSION,
        SEL_CONFIG,
        SEL_RESULT,
        SEL_FINXOR
    } rd_sel_e;

    // one-cycle write strobes produced in the access phase
    typedef struct packed {
        logic restart;
        logic feed;
        logic finxor;
    } wr_strobe_t;

endpackage

// File: rtl/wordcrc_bitrev.sv
// wordcrc_bitrev: optional bit reversal of a W-bit vector.
// Pure wiring; ENABLE=0 passes the vector straight through.
module wordcrc_bitrev #(
    parameter int unsigned W      = 32,
    parameter bit          ENABLE = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (ENABLE) begin : g_rev
            for (genvar i = 0; i < W; i++) begin : g_bit
                // mirror bit i to bit W-1-i
                assign dout[i] = din[W-1-i];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/wordcrc_fold.sv
// wordcrc_fold: combinational next remainder after shifting one W-bit
// word through an MSB-first CRC register. Built as W unrolled
// shift-and-conditional-XOR stages; word bit W-1 enters first.
// Assumes POLY has its implicit top term omitted.
module wordcrc_fold #(
    parameter int unsigned     W    = 32,
    parameter logic [W-1:0]    POLY = 32'h04C1_1DB7
) (
    input  logic [W-1:0] state,
    input  logic [W-1:0] word,
    output logic [W-1:0] next
);

    generate
        for (genvar k = 0; k < W; k++) begin : g_step
            logic [W-1:0] st_in;
            logic [W-1:0] st_out;
            logic         fb;

            if (k == 0) begin : g_first
                assign st_in = state;
            end else begin : g_chain
                assign st_in = g_step[k-1].st_out;
            end

            // feedback bit: outgoing MSB against the incoming data bit
            assign fb     = st_in[W-1] ^ word[W-1-k];
            // shift left and apply the generator when feedback is set
            assign st_out = {st_in[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign next = g_step[W-1].st_out;

endmodule

// File: rtl/wordcrc_core.sv
// wordcrc_core: holds the CRC remainder and updates it by one full word
// per feed strobe. A restart strobe reloads the start value. Input and
// output bit reversal are build-time options.
// Assumes restart and feed are never high in the same cycle; restart wins.
module wordcrc_core #(
    parameter int unsigned  W        = 32,
    parameter logic [W-1:0] POLY     = 32'h04C1_1DB7,
    parameter logic [W-1:0] INIT     = 32'hFFFF_FFFF,
    parameter bit           REFL_IN  = 1'b1,
    parameter bit           REFL_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         feed,
    input  logic [W-1:0] word,
    output logic [W-1:0] state_view
);

    logic [W-1:0] crc_q;
    logic [W-1:0] word_ord;
    logic [W-1:0] crc_next;

    wordcrc_bitrev #(.W(W), .ENABLE(REFL_IN)) u_in_rev (
        .din  (word),
        .dout (word_ord)
    );

    wordcrc_fold #(.W(W), .POLY(POLY)) u_fold (
        .state (crc_q),
        .word  (word_ord),
        .next  (crc_next)
    );

    wordcrc_bitrev #(.W(W), .ENABLE(REFL_OUT)) u_out_rev (
        .din  (crc_q),
        .dout (state_view)
    );

    // remainder register: reset/restart to start value, feed folds a word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (restart) begin
            crc_q <= INIT;
        end else if (feed) begin
            crc_q <= crc_next;
        end
    end

    // R3
    restart_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (crc_q == INIT));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !feed) |=> $stable(crc_q));

endmodule

// File: rtl/wordcrc_decode.sv
// wordcrc_decode: APB address decode. Produces one-cycle write strobes
// in the access phase and a read-source select for reads.
// Assumes full-address compare; unaligned offsets decode as unmapped.
module wordcrc_decode
    import wordcrc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter bit          XOR_PRESENT = 1'b1
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output wr_strobe_t        strb,
    output rd_sel_e           rsel
);

    // write strobes only when select, enable and write are all high
    always_comb begin
        strb = '0;
        if (psel && penable && pwrite) begin
            case (paddr)
                ADDR_W'(OFS_RESTART): strb.restart = 1'b1;
                ADDR_W'(OFS_FEED):    strb.feed    = 1'b1;
                ADDR_W'(OFS_FINXOR):  strb.finxor  = XOR_PRESENT;
                default:              strb         = '0;
            endcase
        end
    end

    // read source select for any selected read cycle
    always_comb begin
        rsel = SEL_NONE;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFS_IDENT):   rsel = SEL_IDENT;
                ADDR_W'(OFS_VERSION): rsel = SEL_VERSION;
                ADDR_W'(OFS_CONFIG):  rsel = SEL_CONFIG;
                ADDR_W'(OFS_RESULT):  rsel = SEL_RESULT;
                ADDR_W'(OFS_FINXOR):  rsel = XOR_PRESENT ? SEL_FINXOR : SEL_NONE;
                default:              rsel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/wordcrc_periph.sv
// wordcrc_periph: APB slave wrapping the word-wide CRC engine.
// Holds the final XOR mask (writable when XOR_PRESENT) and muxes read
// data. Zero-wait, never errors. Assumes standard two-phase APB transfers.
module wordcrc_periph
    import wordcrc_pkg::*;
#(
    parameter int unsigned      ADDR_W      = 8,
    parameter logic [CRC_W-1:0] POLY        = 32'h04C1_1DB7,
    parameter logic [CRC_W-1:0] INIT        = 32'hFFFF_FFFF,
    parameter bit               REFL_IN     = 1'b1,
    parameter bit               REFL_OUT    = 1'b1,
    parameter logic [CRC_W-1:0] FINAL_XOR   = 32'hFFFF_FFFF,
    parameter bit               XOR_PRESENT = 1'b1
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CRC_W-1:0]  pwdata,
    output logic [CRC_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr
);

    localparam int unsigned     PAD_W    = CRC_W - 11;
    localparam logic [CRC_W-1:0] CFG_WORD =
        {{PAD_W{1'b0}}, XOR_PRESENT, REFL_OUT, REFL_IN, 8'(CRC_W)};

    wr_strobe_t       strb;
    rd_sel_e          rsel;
    logic [CRC_W-1:0] state_view;
    logic [CRC_W-1:0] finxor_q;

    wordcrc_decode #(.ADDR_W(ADDR_W), .XOR_PRESENT(XOR_PRESENT)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .strb    (strb),
        .rsel    (rsel)
    );

    wordcrc_core #(
        .W        (CRC_W),
        .POLY     (POLY),
        .INIT     (INIT),
        .REFL_IN  (REFL_IN),
        .REFL_OUT (REFL_OUT)
    ) u_core (
        .clk        (pclk),
        .rst_n      (presetn),
        .restart    (strb.restart),
        .feed       (strb.feed),
        .word       (pwdata),
        .state_view (state_view)
    );

    generate
        if (XOR_PRESENT) begin : g_finxor_rw
            // mask register: reset to the build constant, loaded by writes
            always_ff @(posedge pclk) begin
                if (!presetn) begin
                    finxor_q <= FINAL_XOR;
                end else if (strb.finxor) begin
                    finxor_q <= pwdata;
                end
            end

            // R4
            finxor_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
                strb.finxor |=> (finxor_q == $past(pwdata)));
        end else begin : g_finxor_fixed
            assign finxor_q = FINAL_XOR;
        end
    endgenerate

    // read data multiplexer
    always_comb begin
        case (rsel)
            SEL_IDENT:   prdata = {IDENT_API, IDENT_LEN, IDENT_NUM};
            SEL_VERSION: prdata = {VER_MAJOR, VER_MINOR, VER_PATCH};
            SEL_CONFIG:  prdata = CFG_WORD;
            SEL_RESULT:  prdata = state_view ^ finxor_q;
            SEL_FINXOR:  prdata = finxor_q;
            default:     prdata = '0;
        endcase
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R7
    unmapped_rd_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && rsel == SEL_NONE) |-> (prdata == '0));

    // R5
    cfg_rd_fmt_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr == ADDR_W'(OFS_CONFIG))
            |-> (prdata[7:0] == 8'd32 && prdata[CRC_W-1:11] == '0));

endmodule

// File: tb/sim_wordcrc_periph.sv
// Self-checking bench: behavioural shift-right CRC model, compared on
// every read transfer and every clock (handshake outputs).
module sim_wordcrc_periph;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_crc;   // model remainder, kept in reflected order
    logic [31:0] m_xor;   // model mask
    logic [31:0] rd;
    logic [31:0] rng;

    always #5 clk = ~clk;

    wordcrc_periph u0 (
        .pclk    (clk),
        .presetn (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr)
    );

    function automatic logic [31:0] model_feed(input logic [31:0] crc,
                                               input logic [31:0] w);
        logic [31:0] c;
        c = crc ^ w;
        for (int i = 0; i < 32; i++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 r = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a,
                          input logic [31:0] exp);
        logic [31:0] r;
        xfer(1'b0, a, 32'h0, r);
        check(tag, r, exp);
    endtask

    task automatic feed(input logic [31:0] w);
        wr(8'h10, w);
        m_crc = model_feed(m_crc, w);
    endtask

    task automatic restart(input logic [31:0] junk);
        wr(8'h0C, junk);
        m_crc = 32'hFFFF_FFFF;
    endtask

    // R8: handshake outputs compared every clock after reset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 pready", {31'd0, pready}, 32'd1);
            check("R8 pslverr", {31'd0, pslverr}, 32'd0);
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_crc = 32'hFFFF_FFFF;
        m_xor = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 result after reset", 8'h14, 32'h0000_0000);
        rd_chk("R1 mask after reset", 8'h18, 32'hFFFF_FFFF);
        // R6 identity and version
        rd_chk("R6 ident", 8'h00, 32'h0008_0012);
        rd_chk("R6 version", 8'h04, 32'h0100_0000);
        // R5 build options
        rd_chk("R5 config", 8'h08, 32'h0000_0720);

        // R2 known constant for one zero word; R10 read right after write
        feed(32'h0000_0000);
        rd_chk("R2 zero word constant", 8'h14, 32'h2144_DF1C);
        check("R2 model agrees", m_crc ^ m_xor, 32'h2144_DF1C);

        // R3 restart with non-zero data
        restart(32'hDEAD_BEEF);
        rd_chk("R3 restart ignores data", 8'h14, 32'h0000_0000);

        // R2 patterns: all ones, alternating bytes, walking one
        feed(32'hFFFF_FFFF);
        rd_chk("R2 all ones", 8'h14, m_crc ^ m_xor);
        feed(32'hA55A_A55A);
        rd_chk("R2 alternating", 8'h14, m_crc ^ m_xor);
        for (int b = 0; b < 32; b++) begin
            restart(32'h0);
            feed(32'h1 << b);
            rd_chk($sformatf("R2 walking one bit %0d", b), 8'h14, m_crc ^ m_xor);
        end

        // R4 mask changes the result at once and reads back
        wr(8'h18, 32'h0000_0000);
        m_xor = 32'h0;
        rd_chk("R4 mask readback zero", 8'h18, 32'h0);
        rd_chk("R4 raw remainder", 8'h14, m_crc);
        wr(8'h18, 32'h1234_5678);
        m_xor = 32'h1234_5678;
        rd_chk("R4 mask readback", 8'h18, 32'h1234_5678);
        rd_chk("R4 result with mask", 8'h14, m_crc ^ m_xor);

        // R7 writes to read-only and unmapped offsets change nothing
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0);
        wr(8'h14, 32'hCAFE_F00D);
        wr(8'h1C, 32'hCAFE_F00D);
        wr(8'h11, 32'hCAFE_F00D);
        rd_chk("R7 ident unchanged", 8'h00, 32'h0008_0012);
        rd_chk("R7 version unchanged", 8'h04, 32'h0100_0000);
        rd_chk("R7 config unchanged", 8'h08, 32'h0000_0720);
        rd_chk("R7 result unchanged", 8'h14, m_crc ^ m_xor);
        rd_chk("R7 mask unchanged", 8'h18, m_xor);
        // R7 reads of write-only, unmapped and unaligned offsets
        rd_chk("R7 restart reads zero", 8'h0C, 32'h0);
        rd_chk("R7 feed reads zero", 8'h10, 32'h0);
        rd_chk("R7 unmapped 0x1C", 8'h1C, 32'h0);
        rd_chk("R7 unmapped 0xFC", 8'hFC, 32'h0);
        rd_chk("R7 unaligned 0x02", 8'h02, 32'h0);
        rd_chk("R7 unaligned 0x15", 8'h15, 32'h0);

        // R9 setup phase without access phase: no state change
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = 8'h10; pwdata = 32'h7777_1111;
        @(negedge clk);
        paddr = 8'h18;
        @(negedge clk);
        paddr = 8'h0C;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        rd_chk("R9 result after aborted setup", 8'h14, m_crc ^ m_xor);
        rd_chk("R9 mask after aborted setup", 8'h18, m_xor);

        // R2/R10 long pseudo-random stream with the default mask
        wr(8'h18, 32'hFFFF_FFFF);
        m_xor = 32'hFFFF_FFFF;
        restart(32'h5555_AAAA);
        rng = 32'h1357_9BDF;
        for (int n = 0; n < 200; n++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            feed(rng);
            if (n % 10 == 9)
                rd_chk($sformatf("R10 stream word %0d", n), 8'h14, m_crc ^ m_xor);
        end

        // R1 reset mid-stream restores start value and mask
        wr(8'h18, 32'hABCD_0000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_crc = 32'hFFFF_FFFF;
        m_xor = 32'hFFFF_FFFF;
        rd_chk("R1 result after second reset", 8'h14, 32'h0);
        rd_chk("R1 mask after second reset", 8'h18, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule